// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit arithmetic and logic unit of an accumulator machine. Each transaction carries an operation code, the accumulator value A, a second operand B and the current carry, auxiliary-carry and overflow flags. It returns a new A value, a new B value, the three flags, and a write mask. The mask tells the status register which of the returned flags it should store. The operations are add, add with carry, subtract with borrow, bitwise AND/OR/XOR, the two-register multiply and divide, decimal adjust, plain rotates and rotates through carry, nibble swap, low-nibble exchange and an unsigned compare.

Transactions enter and leave through valid/ready streams. A transaction is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Its result is registered at that edge and is offered on the output side from the next cycle. The output side applies back-pressure: while `out_valid` is high and `out_ready` is low, the result is held and no new transaction is taken. When the output register is empty, or is being drained in the same cycle, a new transaction can enter. With `out_ready` tied high the block therefore accepts one operation per clock.

Top module: `acc_alu`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An accepted transaction shows `out_valid` high on the next cycle. While `out_valid && !out_ready` holds, every output value stays unchanged. After reset `out_valid` is 0.
- R2: Flag vectors use bit 2 = carry, bit 1 = auxiliary carry and bit 0 = overflow, for both flags and mask. A flag whose mask bit is 0 is returned equal to the incoming flag. Operations that leave B alone return `out_b = in_b`.
- R3: Op 0 (add) computes A+B and ignores the carry input. Op 1 (add with carry) computes A+B+carry. Both set carry to the carry out of bit 7, auxiliary carry to the carry out of bit 3, and overflow on two's-complement overflow. The mask is 3'b111.
- R4: Op 2 (subtract with borrow) computes A−B−carry. Carry is set on a borrow out of bit 7, auxiliary carry on a borrow out of bit 3, and overflow on two's-complement overflow. The mask is 3'b111.
- R5: Ops 3, 4 and 5 return A AND B, A OR B and A XOR B. The mask is 3'b000.
- R6: Op 6 (multiply) returns the high byte of A×B in `out_b` and the low byte in `out_a`. It clears carry and sets overflow when the product exceeds 255. The mask is 3'b101.
- R7: Op 7 (divide) returns the quotient in `out_a` and the remainder in `out_b`, clears carry and clears overflow. With B = 0, overflow is set and both results are 0. The mask is 3'b101.
- R8: Op 8 (decimal adjust) first adds 6 when the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 when the high nibble exceeds 9 or carry is set. Carry is set by either carry out and never cleared. The mask is 3'b100.
- R9: Ops 9 and 11 rotate A left and right by one bit with mask 3'b000. Ops 10 and 12 rotate A left and right through carry, with the bit shifted out becoming carry, and mask 3'b100.
- R10: Op 13 returns A with its nibbles exchanged. Op 14 exchanges bits 3:0 of A and B and leaves the high nibbles in place. Both have mask 3'b000.
- R11: Op 15 (compare) returns A and B unchanged and sets carry when A < B unsigned. The mask is 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Transaction offered |
| in_ready | output | 1 | Transaction can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 8 | Accumulator operand |
| in_b | input | 8 | Second operand |
| in_flags | input | 3 | Incoming flags {carry, aux, overflow} |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Downstream takes the result |
| out_a | output | 8 | New accumulator value |
| out_b | output | 8 | New second-register value |
| out_flags | output | 3 | Resulting flags {carry, aux, overflow} |
| out_we | output | 3 | Flag write mask {carry, aux, overflow} |

## Verification
The properties assume that `in_op`, `in_a` and `in_b` are known whenever `in_valid` is high. They also assume that `rst_n` is released away from a clock edge. Each property samples the inputs only at the acceptance edge and compares them with the result one cycle later. For that reason they also assume that the input values present at that edge belong to the accepted transaction. The bench changes inputs only on falling edges, and only ever raises or lowers `in_valid` together with a complete set of operands. During the stall scenario it offers a second transaction while the first one is held. The properties about accepted operations then still refer to the edge where `in_ready` actually rose.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;
  localparam int FW = 3;
  localparam int F_CY = 2;
  localparam int F_AC = 1;
  localparam int F_OV = 0;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_MUL  = 4'd6,
    OP_DIV  = 4'd7,
    OP_DADJ = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROLC = 4'd10,
    OP_ROR  = 4'd11,
    OP_RORC = 4'd12,
    OP_SWAP = 4'd13,
    OP_XLO  = 4'd14,
    OP_CMP  = 4'd15
  } op_e;
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          cy,
  output logic          ac,
  output logic          ov
);
  logic [DW-1:0] bx;
  logic          ci;
  logic [DW:0]   sum;
  logic [NW:0]   low;

  always_comb begin
    bx  = sub ? ~b : b;
    ci  = sub ? ~cin : cin;
    sum = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, ci};
    low = {1'b0, a[NW-1:0]} + {1'b0, bx[NW-1:0]} + {{NW{1'b0}}, ci};
    res = sum[DW-1:0];
    cy  = sub ? ~sum[DW] : sum[DW];
    ac  = sub ? ~low[NW] : low[NW];
    ov  = (a[DW-1] == bx[DW-1]) && (sum[DW-1] != a[DW-1]);
  end
endmodule

// File: rtl/acc_muldiv.sv
module acc_muldiv
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] mul_lo,
  output logic [DW-1:0] mul_hi,
  output logic          mul_ov,
  output logic [DW-1:0] div_q,
  output logic [DW-1:0] div_r,
  output logic          div_ov
);
  logic [2*DW-1:0] prod;
  logic [DW-1:0]   dvsr;
  logic            zero_b;

  always_comb begin
    prod   = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    mul_lo = prod[DW-1:0];
    mul_hi = prod[2*DW-1:DW];
    mul_ov = |mul_hi;
    zero_b = (b == '0);
    dvsr   = zero_b ? {{(DW-1){1'b0}}, 1'b1} : b;
    div_q  = zero_b ? '0 : a / dvsr;
    div_r  = zero_b ? '0 : a % dvsr;
    div_ov = zero_b;
  end
endmodule

// File: rtl/acc_bitops.sv
module acc_bitops
  import acc_alu_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          acin,
  output logic [DW-1:0] rol,
  output logic [DW-1:0] ror,
  output logic [DW-1:0] rolc,
  output logic [DW-1:0] rorc,
  output logic [DW-1:0] swp,
  output logic [DW-1:0] xlo_a,
  output logic [DW-1:0] xlo_b,
  output logic [DW-1:0] da_res,
  output logic          da_cy,
  output logic          lt
);
  logic          lo_fix, hi_fix, c1;
  logic [DW:0]   t1, t2;

  always_comb begin
    rol   = {a[DW-2:0], a[DW-1]};
    ror   = {a[0], a[DW-1:1]};
    rolc  = {a[DW-2:0], cin};
    rorc  = {cin, a[DW-1:1]};
    swp   = {a[NW-1:0], a[DW-1:NW]};
    xlo_a = {a[DW-1:NW], b[NW-1:0]};
    xlo_b = {b[DW-1:NW], a[NW-1:0]};
    lt    = a < b;

    lo_fix = (a[NW-1:0] > 4'd9) || acin;
    t1     = {1'b0, a} + (lo_fix ? 9'd6 : 9'd0);
    c1     = cin | t1[DW];
    hi_fix = (t1[DW-1:NW] > 4'd9) || c1;
    t2     = {1'b0, t1[DW-1:0]} + (hi_fix ? 9'h060 : 9'd0);
    da_res = t2[DW-1:0];
    da_cy  = c1 | t2[DW];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    in_op,
  input  logic [7:0]    in_a,
  input  logic [7:0]    in_b,
  input  logic [2:0]    in_flags,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_a,
  output logic [7:0]    out_b,
  output logic [2:0]    out_flags,
  output logic [2:0]    out_we
);
  op_e           op;
  logic          cin, acin, take;
  logic [DW-1:0] as_res;
  logic          as_cy, as_ac, as_ov, as_sub, as_cin;
  logic [DW-1:0] m_lo, m_hi, d_q, d_r;
  logic          m_ov, d_ov;
  logic [DW-1:0] rol, ror, rolc, rorc, swp, xlo_a, xlo_b, da_res;
  logic          da_cy, lt;
  logic [DW-1:0] nx_a, nx_b;
  logic [FW-1:0] nx_f, nx_we, nx_out;

  assign op     = op_e'(in_op);
  assign cin    = in_flags[F_CY];
  assign acin   = in_flags[F_AC];
  assign as_sub = (op == OP_SUBB);
  assign as_cin = (op == OP_ADD) ? 1'b0 : cin;

  acc_addsub u_as (
    .a(in_a), .b(in_b), .cin(as_cin), .sub(as_sub),
    .res(as_res), .cy(as_cy), .ac(as_ac), .ov(as_ov)
  );

  acc_muldiv u_md (
    .a(in_a), .b(in_b), .mul_lo(m_lo), .mul_hi(m_hi), .mul_ov(m_ov),
    .div_q(d_q), .div_r(d_r), .div_ov(d_ov)
  );

  acc_bitops u_bo (
    .a(in_a), .b(in_b), .cin(cin), .acin(acin),
    .rol(rol), .ror(ror), .rolc(rolc), .rorc(rorc), .swp(swp),
    .xlo_a(xlo_a), .xlo_b(xlo_b), .da_res(da_res), .da_cy(da_cy), .lt(lt)
  );

  always_comb begin
    nx_a  = in_a;
    nx_b  = in_b;
    nx_f  = in_flags;
    nx_we = 3'b000;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        nx_a  = as_res;
        nx_f  = {as_cy, as_ac, as_ov};
        nx_we = 3'b111;
      end
      OP_AND:  nx_a = in_a & in_b;
      OP_OR:   nx_a = in_a | in_b;
      OP_XOR:  nx_a = in_a ^ in_b;
      OP_MUL: begin
        nx_a  = m_lo;
        nx_b  = m_hi;
        nx_f  = {1'b0, acin, m_ov};
        nx_we = 3'b101;
      end
      OP_DIV: begin
        nx_a  = d_q;
        nx_b  = d_r;
        nx_f  = {1'b0, acin, d_ov};
        nx_we = 3'b101;
      end
      OP_DADJ: begin
        nx_a        = da_res;
        nx_f[F_CY]  = da_cy;
        nx_we       = 3'b100;
      end
      OP_ROL:  nx_a = rol;
      OP_ROR:  nx_a = ror;
      OP_ROLC: begin
        nx_a       = rolc;
        nx_f[F_CY] = in_a[DW-1];
        nx_we      = 3'b100;
      end
      OP_RORC: begin
        nx_a       = rorc;
        nx_f[F_CY] = in_a[0];
        nx_we      = 3'b100;
      end
      OP_SWAP: nx_a = swp;
      OP_XLO: begin
        nx_a = xlo_a;
        nx_b = xlo_b;
      end
      OP_CMP: begin
        nx_f[F_CY] = lt;
        nx_we      = 3'b100;
      end
      default: ;
    endcase
    nx_out = (nx_we & nx_f) | (~nx_we & in_flags);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_a     <= '0;
      out_b     <= '0;
      out_flags <= '0;
      out_we    <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_a     <= nx_a;
      out_b     <= nx_b;
      out_flags <= nx_out;
      out_we    <= nx_we;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [3:0] in_op,
  input logic [7:0] in_a,
  input logic [7:0] in_b,
  input logic [2:0] in_flags,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_a,
  input logic [7:0] out_b,
  input logic [2:0] out_flags,
  input logic [2:0] out_we
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_accept_shows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_stall_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_a) && $stable(out_b) && $stable(out_flags) && $stable(out_we)));

  p_add_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'd0) |=> (out_we == 3'b111 && out_a == 8'($past(in_a) + $past(in_b))));

  p_logic_nomask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == 4'd3 || in_op == 4'd4 || in_op == 4'd5)) |=>
      (out_we == 3'b000 && out_flags == $past(in_flags)));

  p_mul_clears_cy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'd6) |=> (!out_flags[2] && out_we == 3'b101));

  p_div_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'd7 && in_b == 8'd0) |=>
      (out_flags[0] && !out_flags[2] && out_a == 8'd0 && out_b == 8'd0));

  p_da_never_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'd8 && in_flags[2]) |=> out_flags[2]);

  p_swap_nibbles_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'd13) |=> (out_a == {$past(in_a[3:0]), $past(in_a[7:4])}));

  p_cmp_keeps_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'd15) |=> (out_a == $past(in_a) && out_b == $past(in_b) && out_we == 3'b100));
endmodule

bind acc_alu acc_alu_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_flags(in_flags),
  .out_valid(out_valid), .out_ready(out_ready), .out_a(out_a), .out_b(out_b),
  .out_flags(out_flags), .out_we(out_we)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic [2:0] in_flags = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_a, out_b;
  logic [2:0] out_flags, out_we;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  acc_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_flags(in_flags),
    .out_valid(out_valid), .out_ready(out_ready), .out_a(out_a), .out_b(out_b),
    .out_flags(out_flags), .out_we(out_we)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected < 190000", cyc);
      report();
    end
  end

  function automatic string req_of(input int op);
    case (op)
      0, 1: return "R3";
      2: return "R4";
      3, 4, 5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9, 10, 11, 12: return "R9";
      13, 14: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model(input int op, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] fi, output logic [7:0] ea,
                       output logic [7:0] eb, output logic [2:0] ef,
                       output logic [2:0] ew);
    int c, x, s, sg;
    logic cy, ac, ov;
    logic [3:0] lo;
    c = int'(fi[2]);
    ea = a; eb = b; ew = 3'b000;
    cy = fi[2]; ac = fi[1]; ov = fi[0];
    case (op)
      0, 1: begin
        x  = (op == 1) ? c : 0;
        s  = int'(a) + int'(b) + x;
        sg = int'($signed(a)) + int'($signed(b)) + x;
        ea = s[7:0]; cy = s > 255;
        ac = (int'(a[3:0]) + int'(b[3:0]) + x) > 15;
        ov = (sg > 127) || (sg < -128); ew = 3'b111;
      end
      2: begin
        s  = int'(a) - int'(b) - c;
        sg = int'($signed(a)) - int'($signed(b)) - c;
        ea = s[7:0]; cy = s < 0;
        ac = (int'(a[3:0]) - int'(b[3:0]) - c) < 0;
        ov = (sg > 127) || (sg < -128); ew = 3'b111;
      end
      3: ea = a & b;
      4: ea = a | b;
      5: ea = a ^ b;
      6: begin
        s = int'(a) * int'(b);
        ea = s[7:0]; eb = s[15:8]; cy = 1'b0; ov = s > 255; ew = 3'b101;
      end
      7: begin
        cy = 1'b0; ew = 3'b101;
        if (b == 0) begin ea = 0; eb = 0; ov = 1'b1; end
        else begin ea = a / b; eb = a % b; ov = 1'b0; end
      end
      8: begin
        s = int'(a);
        lo = a[3:0];
        if (lo > 9 || fi[1]) s = s + 6;
        if (s > 255) cy = 1'b1;
        if (((s >> 4) & 15) > 9 || cy) s = (s & 255) + 96;
        if (s > 255) cy = 1'b1;
        ea = s[7:0]; ew = 3'b100;
      end
      9:  ea = {a[6:0], a[7]};
      10: begin ea = {a[6:0], fi[2]}; cy = a[7]; ew = 3'b100; end
      11: ea = {a[0], a[7:1]};
      12: begin ea = {fi[2], a[7:1]}; cy = a[0]; ew = 3'b100; end
      13: ea = {a[3:0], a[7:4]};
      14: begin ea = {a[7:4], b[3:0]}; eb = {b[7:4], a[3:0]}; end
      default: begin cy = a < b; ew = 3'b100; end
    endcase
    ef = {cy, ac, ov};
  endtask

  task automatic apply(input int op, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] fi);
    logic [7:0] ea, eb;
    logic [2:0] ef, ew;
    model(op, a, b, fi, ea, eb, ef, ew);
    @(negedge clk);
    in_op = op[3:0]; in_a = a; in_b = b; in_flags = fi; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_chk++;
    if (!out_valid || out_a !== ea || out_b !== eb || out_flags !== ef || out_we !== ew) begin
      n_bad++;
      $display("FAIL %s op%0d a=%h b=%h f=%b: actual v%b %h %h %b %b expected v1 %h %h %b %b",
               req_of(op), op, a, b, fi, out_valid, out_a, out_b, out_flags, out_we,
               ea, eb, ef, ew);
    end
  endtask

  task automatic t_reset();
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 reset: actual valid=%b ready=%b expected 0 1", out_valid, in_ready);
    end
  endtask

  // R3..R11 and R2 (passthrough of unmasked flags) swept per op
  task automatic t_sweep(input int op);
    for (int i = 0; i <= 24; i++) begin
      for (int j = 0; j <= 20; j++) begin
        for (int f = 0; f < 4; f++) begin
          logic [7:0] a, b;
          logic [2:0] fl;
          a  = (i == 24) ? 8'hFF : 8'(i * 11);
          b  = (j == 20) ? 8'hFF : 8'(j * 13);
          fl = {f[1], f[0], f[1] ^ f[0]};
          apply(op, a, b, fl);
        end
      end
    end
  endtask

  task automatic t_corners();
    apply(6, 8'hFF, 8'hFF, 3'b100);   // R6 largest product
    apply(7, 8'h00, 8'h00, 3'b111);   // R7 divide by zero
    apply(7, 8'hFF, 8'h01, 3'b100);   // R7
    apply(8, 8'h9A, 8'h00, 3'b000);   // R8 both nibbles adjust
    apply(8, 8'h99, 8'h00, 3'b100);   // R8 carry kept
    apply(2, 8'h80, 8'h01, 3'b000);   // R4 signed overflow
    apply(1, 8'h7F, 8'h00, 3'b100);   // R3 carry into sign
  endtask

  task automatic t_stall();
    logic [7:0] held;
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'd0; in_a = 8'h12; in_b = 8'h34; in_flags = 3'b000; in_valid = 1'b1;
    @(negedge clk);
    in_a = 8'h01; in_b = 8'h01;        // second offer, must wait
    held = out_a;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      n_chk++;
      if (!out_valid || in_ready || out_a !== 8'h46 || out_a !== held) begin
        n_bad++;
        $display("FAIL R1 stall: actual v%b r%b a=%h expected v1 r0 a=46", out_valid, in_ready, out_a);
      end
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_chk++;
    if (!out_valid || out_a !== 8'h02) begin
      n_bad++;
      $display("FAIL R1 release: actual v%b a=%h expected v1 a=02", out_valid, out_a);
    end
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 drain: actual v%b expected v0", out_valid);
    end
  endtask

  initial begin
    #25 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stall();
    t_corners();
    for (int op = 0; op < 16; op++) t_sweep(op);
    report();
  end
endmodule